// File: doc/BRIEF.md
# Response Error Status Router

This block sits in the receive path of a packetized serial memory link controller, after link-level checking and packet decoding. It examines each incoming response: the command type, the error-status field and the sequence number. From these it decides where the response goes. It may be forwarded to the application with the response-error flag low. It may be forwarded with the flag raised. Or it may be diverted, so that it never reaches the application.

Error-type responses that carry a non-zero status are diverted. Their status and cube-identifier values are stored as one entry in a small queue. The oldest entry of that queue is always visible on a status output, and software removes it with a one-cycle acknowledge strobe.

The block also tracks the expected sequence number. It keeps two sticky interrupt bits: one for a sequence mismatch and one for a queue overflow. Writing a one to an interrupt bit clears it.

A two-state controller owns the forwarding register:
- `ST_PASS`: the output register is empty.
- `ST_HOLD`: the output register holds a response the application has not yet taken.

The controller has these transitions:
- `ST_PASS -> ST_HOLD` when a response that is forwarded is accepted.
- `ST_HOLD -> ST_HOLD` when the application takes the held response and a new forwarded response is accepted in the same cycle.
- `ST_HOLD -> ST_PASS` when the application takes the held response and nothing new is loaded.
- `ST_PASS -> ST_PASS` when the input is idle, or when the accepted response is diverted.

Top module: `rsp_err_router`

## Requirements
- R1: A response whose error-status field is zero is forwarded in the cycle after acceptance, with its command and data unchanged, and with `out_rsp_error` low.
- R2: A read (cmd 0), write (cmd 1) or mode (cmd 2) response with a non-zero error-status field is forwarded with `out_rsp_error` high.
- R3: An error-type response (cmd 3) with a non-zero error-status field is never forwarded. Its status and cube identifier are pushed as one entry into the error queue, in arrival order.
- R4: `ersp_errstat` and `ersp_cube` show the oldest queue entry, and they stay unchanged while `ersp_ack` is low.
- R5: A high `ersp_ack` removes the oldest entry. An ack on an empty queue has no effect. `ersp_valid` is low exactly when the queue is empty.
- R6: When the queue holds QDEPTH entries and no entry is removed in the same cycle, a new diverted entry is dropped and `irq_overflow` is set. The stored entries are left as they were.
- R7: The expected sequence number starts at 0 after reset and increments modulo 8 on every accepted response. An accepted response with a different `in_seq` sets the sticky `irq_seq_err`.
- R8: `irq_clear[0]` clears `irq_seq_err` and `irq_clear[1]` clears `irq_overflow`. A new set event in the same cycle wins over the clear.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and all forwarded outputs hold steady. While `out_ready` is high, one response per cycle is accepted.
- R10: After reset `out_valid`, `ersp_valid`, `irq_seq_err` and `irq_overflow` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded response present |
| in_ready | output | 1 | Block accepts the response |
| in_cmd | input | 2 | Command type: 0 read, 1 write, 2 mode, 3 error |
| in_errstat | input | ERRSTAT_W | Error-status field |
| in_cube | input | CUBE_W | Cube identifier |
| in_seq | input | SEQ_W | Sequence number |
| in_data | input | DATA_W | Response payload |
| out_valid | output | 1 | Forwarded response present |
| out_ready | input | 1 | Application takes the response |
| out_cmd | output | 2 | Forwarded command type |
| out_data | output | DATA_W | Forwarded payload |
| out_rsp_error | output | 1 | Forwarded response carried a non-zero status |
| ersp_valid | output | 1 | Error queue is not empty |
| ersp_errstat | output | ERRSTAT_W | Status of the oldest queued entry |
| ersp_cube | output | CUBE_W | Cube identifier of the oldest queued entry |
| ersp_ack | input | 1 | One-cycle strobe that removes the oldest entry |
| irq_seq_err | output | 1 | Sticky sequence-mismatch bit |
| irq_overflow | output | 1 | Sticky queue-overflow bit |
| irq_clear | input | 2 | Write-one-to-clear: bit 0 sequence, bit 1 overflow |

## Verification
A wrong controller state appears at the ports in the next cycle. It shows up either as `out_valid` disagreeing with the handshake history, or as `in_ready` dropping while `out_ready` is high. A corrupted queue pointer or count may stay hidden until the affected entry reaches the head. The bench therefore compares the head, the valid bit and the overflow bit every cycle, through fill, overflow and drain sequences. An expected sequence number that is off by one raises `irq_seq_err` at the first accepted response, and that bit stays set until it is cleared.

// File: rtl/rsp_err_pkg.sv
package rsp_err_pkg;
    typedef enum logic [1:0] {
        CMD_READ  = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_MODE  = 2'd2,
        CMD_ERROR = 2'd3
    } rsp_cmd_e;

    typedef enum logic {
        ST_PASS = 1'b0,
        ST_HOLD = 1'b1
    } rtr_state_e;
endpackage

// File: rtl/rsp_classify.sv
module rsp_classify
    import rsp_err_pkg::*;
#(
    parameter int ERRSTAT_W = 7
) (
    input  logic [1:0]           cmd,
    input  logic [ERRSTAT_W-1:0] errstat,
    output logic                 divert,
    output logic                 flag
);
    always_comb begin
        flag   = (errstat != '0);
        divert = flag && (rsp_cmd_e'(cmd) == CMD_ERROR);
    end
endmodule

// File: rtl/seq_tracker.sv
module seq_tracker #(
    parameter int SEQ_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [SEQ_W-1:0] seq_in,
    output logic             mismatch
);
    logic [SEQ_W-1:0] expect_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            expect_q <= '0;
        else if (accept)
            expect_q <= expect_q + 1'b1;
    end

    assign mismatch = accept && (seq_in != expect_q);
endmodule

// File: rtl/err_queue.sv
module err_queue #(
    parameter int EW    = 10,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [EW-1:0] din,
    input  logic          pop,
    output logic [EW-1:0] head,
    output logic          not_empty,
    output logic          dropped
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    logic [EW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          pop_ok, push_ok;

    assign not_empty = (count != '0);
    assign pop_ok    = pop && not_empty;
    assign push_ok   = push && ((count != FULLC) || pop_ok);
    assign dropped   = push && !push_ok;
    assign head      = not_empty ? mem[rd_ptr] : '0;

    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok)
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (push_ok && !pop_ok)
                count <= count + 1'b1;
            else if (pop_ok && !push_ok)
                count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/rsp_err_router.sv
module rsp_err_router
    import rsp_err_pkg::*;
#(
    parameter int ERRSTAT_W = 7,
    parameter int CUBE_W    = 3,
    parameter int SEQ_W     = 3,
    parameter int DATA_W    = 32,
    parameter int QDEPTH    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [1:0]           in_cmd,
    input  logic [ERRSTAT_W-1:0] in_errstat,
    input  logic [CUBE_W-1:0]    in_cube,
    input  logic [SEQ_W-1:0]     in_seq,
    input  logic [DATA_W-1:0]    in_data,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [1:0]           out_cmd,
    output logic [DATA_W-1:0]    out_data,
    output logic                 out_rsp_error,
    output logic                 ersp_valid,
    output logic [ERRSTAT_W-1:0] ersp_errstat,
    output logic [CUBE_W-1:0]    ersp_cube,
    input  logic                 ersp_ack,
    output logic                 irq_seq_err,
    output logic                 irq_overflow,
    input  logic [1:0]           irq_clear
);
    localparam int EW = ERRSTAT_W + CUBE_W;

    rtr_state_e    state_q, state_d;
    logic          accept, divert, flag, load, push, mismatch, dropped;
    logic [EW-1:0] head;

    assign in_ready = (state_q == ST_PASS) || out_ready;
    assign accept   = in_valid && in_ready;

    rsp_classify #(.ERRSTAT_W(ERRSTAT_W)) u_classify (
        .cmd     (in_cmd),
        .errstat (in_errstat),
        .divert  (divert),
        .flag    (flag)
    );

    seq_tracker #(.SEQ_W(SEQ_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .seq_in   (in_seq),
        .mismatch (mismatch)
    );

    err_queue #(.EW(EW), .DEPTH(QDEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .din       ({in_errstat, in_cube}),
        .pop       (ersp_ack),
        .head      (head),
        .not_empty (ersp_valid),
        .dropped   (dropped)
    );

    assign ersp_errstat = head[EW-1:CUBE_W];
    assign ersp_cube    = head[CUBE_W-1:0];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_PASS;
        else
            state_q <= state_d;
    end

    // next state and routing decisions
    always_comb begin
        state_d = state_q;
        push    = accept && divert;
        load    = accept && !divert;
        unique case (state_q)
            ST_PASS: begin
                if (load)
                    state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (out_ready && !load)
                    state_d = ST_PASS;
            end
            default: state_d = ST_PASS;
        endcase
    end

    assign out_valid = (state_q == ST_HOLD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_cmd       <= '0;
            out_data      <= '0;
            out_rsp_error <= 1'b0;
        end else if (load) begin
            out_cmd       <= in_cmd;
            out_data      <= in_data;
            out_rsp_error <= flag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_seq_err  <= 1'b0;
            irq_overflow <= 1'b0;
        end else begin
            irq_seq_err  <= mismatch || (irq_seq_err && !irq_clear[0]);
            irq_overflow <= dropped  || (irq_overflow && !irq_clear[1]);
        end
    end
endmodule

// File: rtl/rsp_err_router_chk.sv
module rsp_err_router_chk #(
    parameter int ERRSTAT_W = 7,
    parameter int DATA_W    = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic [1:0]           in_cmd,
    input logic [ERRSTAT_W-1:0] in_errstat,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [1:0]           out_cmd,
    input logic [DATA_W-1:0]    out_data,
    input logic                 out_rsp_error,
    input logic                 ersp_valid,
    input logic [ERRSTAT_W-1:0] ersp_errstat,
    input logic                 ersp_ack,
    input logic                 irq_seq_err,
    input logic                 irq_overflow,
    input logic [1:0]           irq_clear
);
    p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_cmd) && $stable(out_rsp_error)));

    p_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_cmd != 2'd3 && in_errstat != '0)
        |=> (out_valid && out_rsp_error));

    p_divert_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_cmd == 2'd3 && in_errstat != '0)
        |=> ersp_valid);

    p_head_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ersp_valid && !ersp_ack) |=> (ersp_valid && $stable(ersp_errstat)));

    p_seq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_seq_err && !irq_clear[0]) |=> irq_seq_err);

    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_overflow && !irq_clear[1]) |=> irq_overflow);
endmodule

bind rsp_err_router rsp_err_router_chk #(.ERRSTAT_W(ERRSTAT_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_cmd        (in_cmd),
    .in_errstat    (in_errstat),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_cmd       (out_cmd),
    .out_data      (out_data),
    .out_rsp_error (out_rsp_error),
    .ersp_valid    (ersp_valid),
    .ersp_errstat  (ersp_errstat),
    .ersp_ack      (ersp_ack),
    .irq_seq_err   (irq_seq_err),
    .irq_overflow  (irq_overflow),
    .irq_clear     (irq_clear)
);

// File: tb/test_rsp_err_router.sv
`timescale 1ns/1ps
module test_rsp_err_router;
    localparam int ESW = 7, CBW = 3, SQW = 3, DW = 32, QD = 4;
    localparam real HALF = 2.0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 0, out_ready = 0, ersp_ack = 0;
    logic [1:0] in_cmd = 0, irq_clear = 0;
    logic [ESW-1:0] in_errstat = 0;
    logic [CBW-1:0] in_cube = 0;
    logic [SQW-1:0] in_seq = 0;
    logic [DW-1:0]  in_data = 0;
    logic in_ready, out_valid, out_rsp_error, ersp_valid, irq_seq_err, irq_overflow;
    logic [1:0] out_cmd;
    logic [DW-1:0] out_data;
    logic [ESW-1:0] ersp_errstat;
    logic [CBW-1:0] ersp_cube;

    always #(HALF) clk = ~clk;

    rsp_err_router #(.ERRSTAT_W(ESW), .CUBE_W(CBW), .SEQ_W(SQW), .DATA_W(DW), .QDEPTH(QD)) i_rsp_err_router (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_cmd(in_cmd), .in_errstat(in_errstat), .in_cube(in_cube), .in_seq(in_seq),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_cmd(out_cmd),
        .out_data(out_data), .out_rsp_error(out_rsp_error), .ersp_valid(ersp_valid),
        .ersp_errstat(ersp_errstat), .ersp_cube(ersp_cube), .ersp_ack(ersp_ack),
        .irq_seq_err(irq_seq_err), .irq_overflow(irq_overflow), .irq_clear(irq_clear));

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference state
    bit m_hold, m_flag, m_seqirq, m_ovf;
    logic [1:0] m_cmd;
    logic [DW-1:0] m_data;
    logic [ESW+CBW-1:0] m_q [QD];
    int m_cnt;
    logic [SQW-1:0] m_exp;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit is_divert(logic [1:0] c, logic [ESW-1:0] e);
        return (c == 2'd3) && (e != 0);
    endfunction

    // apply the currently driven inputs for one clock and advance the model
    task automatic step();
        bit rdy, acc, dv, ld, pop, pushok;
        #0.5;
        rdy = !m_hold || out_ready;
        chk("R9 in_ready", in_ready, rdy);
        acc = in_valid && rdy;
        dv  = acc && is_divert(in_cmd, in_errstat);
        ld  = acc && !dv;
        pop = ersp_ack && (m_cnt > 0);
        pushok = dv && ((m_cnt < QD) || pop);
        if (pop) begin
            for (int i = 0; i < QD-1; i++) m_q[i] = m_q[i+1];
            m_cnt--;
        end
        if (pushok) begin
            m_q[m_cnt] = {in_errstat, in_cube};
            m_cnt++;
        end
        m_seqirq = (acc && in_seq != m_exp) || (m_seqirq && !irq_clear[0]);
        m_ovf    = (dv && !pushok) || (m_ovf && !irq_clear[1]);
        if (acc) m_exp = m_exp + 1'b1;
        if (ld) begin
            m_hold = 1; m_cmd = in_cmd; m_data = in_data; m_flag = (in_errstat != 0);
        end else if (m_hold && out_ready) m_hold = 0;
        @(posedge clk);
        @(negedge clk);
        chk("R9 out_valid", out_valid, m_hold);
        if (m_hold) begin
            chk("R1 out_cmd", out_cmd, m_cmd);
            chk("R1 out_data", out_data, m_data);
            chk("R2 out_rsp_error", out_rsp_error, m_flag);
        end
        chk("R5 ersp_valid", ersp_valid, m_cnt > 0);
        if (m_cnt > 0) chk("R4 head", {ersp_errstat, ersp_cube}, m_q[0]);
        chk("R7 irq_seq_err", irq_seq_err, m_seqirq);
        chk("R6 irq_overflow", irq_overflow, m_ovf);
    endtask

    task automatic drive(bit v, logic [1:0] c, logic [ESW-1:0] e, logic [CBW-1:0] cb,
                         bit good_seq, bit ordy, bit ack, logic [1:0] clr);
        in_valid = v; in_cmd = c; in_errstat = e; in_cube = cb;
        in_seq = good_seq ? m_exp : m_exp + 3'd5;
        in_data = $urandom; out_ready = ordy; ersp_ack = ack; irq_clear = clr;
    endtask

    initial begin
        #(2.0 * HALF * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_hold = 0; m_flag = 0; m_seqirq = 0; m_ovf = 0; m_cnt = 0; m_exp = 0;
        m_cmd = 0; m_data = 0;
        for (int i = 0; i < QD; i++) m_q[i] = 0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 out_valid", out_valid, 0);
        chk("R10 ersp_valid", ersp_valid, 0);
        chk("R10 irq_seq_err", irq_seq_err, 0);
        chk("R10 irq_overflow", irq_overflow, 0);
        chk("R10 in_ready", in_ready, 1);
        rst_n = 1;

        // R1 zero status on every command, R2 non-zero on read/write/mode
        for (int c = 0; c < 4; c++) begin drive(1, 2'(c), 0, 1, 1, 1, 0, 0); step(); end
        for (int c = 0; c < 3; c++) begin drive(1, 2'(c), 7'h11, 2, 1, 1, 0, 0); step(); end
        // R3 diverted entries fill queue; R6 overflow with two extra
        for (int k = 0; k < QD + 2; k++) begin
            drive(1, 2'd3, 7'(k + 1), 3'(k), 1, 1, 0, 0); step();
        end
        // R4 head holds while idle
        drive(0, 0, 0, 0, 1, 1, 0, 0); step(); step();
        // R6 push and pop together while full: accepted
        drive(1, 2'd3, 7'h55, 3'd6, 1, 1, 1, 0); step();
        // R8 clear overflow
        drive(0, 0, 0, 0, 1, 1, 0, 2'b10); step();
        // R5 drain plus ack on empty
        for (int k = 0; k < QD + 2; k++) begin drive(0, 0, 0, 0, 1, 1, 1, 0); step(); end
        // R7 bad sequence, then R8 set wins over clear
        drive(1, 2'd0, 0, 0, 0, 1, 0, 0); step();
        drive(1, 2'd1, 0, 0, 0, 1, 0, 2'b01); step();
        drive(0, 0, 0, 0, 1, 1, 0, 2'b01); step();
        // R9 stall with ready low
        drive(1, 2'd0, 7'h3, 0, 1, 0, 0, 0); step(); step(); step();
        drive(1, 2'd1, 0, 0, 1, 1, 0, 0); step(); step();

        // constrained random
        for (int n = 0; n < 3000; n++) begin
            bit v, ordy, ack, gs;
            logic [1:0] clr;
            logic [ESW-1:0] e;
            v    = ($urandom % 4) != 0;
            ordy = ((n / 200) % 2 == 0) ? (($urandom % 4) != 0) : (($urandom % 4) == 0);
            ack  = ($urandom % 5) == 0;
            gs   = ($urandom % 10) != 0;
            clr  = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
            e    = (($urandom % 2) == 0) ? '0 : 7'($urandom);
            drive(v, 2'($urandom), e, 3'($urandom), gs, ordy, ack, clr);
            step();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule